// File: doc/BRIEF.md
# Timer-Driven Converter Start and Serial Readout Sequencer

This block sits on the host side of a serial-output data converter. Each time a periodic timer tick reaches it while it is idle, it raises a conversion-start pulse of fixed length. It then waits for the converter to finish, which the converter signals by driving its busy line from high to low. After that edge it lowers chip-select and reads the 16-bit result as two 8-bit transfers.

The host owns the serial clock, and the converter answers as a slave. The clock idles low. The converter launches each bit on a rising edge, and the host samples it on the following falling edge. The serial clock runs at the system clock divided by an even ratio. Once the second byte is in, the block presents the assembled word and raises a one-cycle valid strobe. It then releases chip-select and waits for the next tick.

Top module: `conv_seq_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, chip-select is high, the serial clock, conversion start and valid are low, and the result is zero.
- R2: A timer tick that arrives while the block is idle raises the conversion-start output for exactly CNV_CYCLES consecutive clock cycles (default 3).
- R3: Readout starts only on a high-to-low transition of busy seen after the conversion-start pulse. Busy that stays low with no preceding high phase does not start a readout.
- R4: A busy falling edge while no conversion has been requested has no effect: chip-select stays high.
- R5: The serial clock idles low. The block produces exactly 8 rising and 8 falling serial-clock edges per byte, 16 per conversion, and samples serial data in on the falling edges.
- R6: Within a byte, the serial-clock period is CLK_DIV system-clock cycles (default 4).
- R7: Chip-select stays low without a break across both bytes of one readout: there is exactly one chip-select rise per conversion.
- R8: The first byte received forms bits 15..8 of the result and the second forms bits 7..0, each MSB first.
- R9: Valid is high for exactly one cycle, in the cycle where chip-select returns high, and the result holds its value between valid strobes.
- R10: A timer tick that arrives while a conversion or a readout is in progress is ignored: there is exactly one conversion-start pulse per conversion.
- R11: Conversion start and active chip-select are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Periodic timer event, one cycle wide |
| busy_i | input | 1 | Converter busy indication (asynchronous) |
| miso_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion-start pulse to the converter |
| cs_n_o | output | 1 | Chip-select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | 16 | Last assembled conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest case to reach from the ports is the edge-sensitive wait. A busy line that is already low when the start pulse ends must not begin a readout, while a later high-then-low pulse must. The bench reaches it by holding busy low through the start pulse and for many cycles afterward. It checks that chip-select stays high, then raises and drops busy to release the transfer. It also fires ticks while the block waits on busy and again in the middle of the serial transfer. It counts the start pulses and chip-select rises to confirm that these ticks changed nothing.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_RD_HI,
        ST_RD_LO
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } result_s;

    function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                     input logic [BYTE_W-1:0] lo);
        result_s r;
        r.hi = hi;
        r.lo = lo;
        return r;
    endfunction

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/conv_seq_edge.sv
module conv_seq_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o
);
    localparam int N = SYNC_STAGES + 1;

    logic [N-1:0] chain;

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign fall_o = chain[N-1] & ~chain[N-2];

endmodule

// File: rtl/conv_seq_clkdiv.sv
module conv_seq_clkdiv #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_en_o
);
    import conv_seq_pkg::*;

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = cnt_width(HALF);

    logic [CW-1:0] cnt;
    logic          sclk_r;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt    <= '0;
            sclk_r <= 1'b0;
        end else if (wrap) begin
            cnt    <= '0;
            sclk_r <= ~sclk_r;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sclk_o    = sclk_r;
    assign fall_en_o = run_i & wrap & sclk_r;

endmodule

// File: rtl/conv_seq_shift.sv
module conv_seq_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic                           miso_i,
    output logic                           sclk_o,
    output logic                           done_o,
    output logic [conv_seq_pkg::BYTE_W-1:0] byte_o
);
    import conv_seq_pkg::*;

    localparam int BW = cnt_width(BYTE_W);

    logic              active;
    logic              fall_en;
    logic [BW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] rx;
    logic              done_q;

    conv_seq_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run_i     (active),
        .sclk_o    (sclk_o),
        .fall_en_o (fall_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            rx      <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                active  <= 1'b1;
                bit_cnt <= '0;
            end else if (fall_en) begin
                rx <= {rx[BYTE_W-2:0], miso_i};
                if (bit_cnt == BW'(BYTE_W - 1)) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign byte_o = rx;

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
    parameter int CNV_CYCLES = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick_i,
    input  logic                           busy_fall_i,
    input  logic                           byte_done_i,
    input  logic [conv_seq_pkg::BYTE_W-1:0] byte_i,
    output logic                           cnv_o,
    output logic                           cs_n_o,
    output logic                           byte_start_o,
    output logic [conv_seq_pkg::WORD_W-1:0] result_o,
    output logic                           valid_o
);
    import conv_seq_pkg::*;

    localparam int CCW = cnt_width(CNV_CYCLES);

    seq_state_e        state, state_nx;
    logic [CCW-1:0]    cnv_cnt;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] result_q;
    logic              valid_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick_i) state_nx = ST_CNV;
            ST_CNV:   if (cnv_cnt == CCW'(CNV_CYCLES - 1)) state_nx = ST_WAIT;
            ST_WAIT:  if (busy_fall_i) state_nx = ST_RD_HI;
            ST_RD_HI: if (byte_done_i) state_nx = ST_RD_LO;
            ST_RD_LO: if (byte_done_i) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnv_cnt  <= '0;
            hi_q     <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            valid_q <= 1'b0;
            if (state == ST_CNV) cnv_cnt <= cnv_cnt + 1'b1;
            else                 cnv_cnt <= '0;
            if (state == ST_RD_HI && byte_done_i) hi_q <= byte_i;
            if (state == ST_RD_LO && byte_done_i) begin
                result_q <= join_bytes(hi_q, byte_i);
                valid_q  <= 1'b1;
            end
        end
    end

    assign byte_start_o = (state == ST_WAIT && busy_fall_i) ||
                          (state == ST_RD_HI && byte_done_i);
    assign cnv_o        = (state == ST_CNV);
    assign cs_n_o       = !(state == ST_RD_HI || state == ST_RD_LO);
    assign result_o     = result_q;
    assign valid_o      = valid_q;

endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top #(
    parameter int CLK_DIV     = 4,
    parameter int CNV_CYCLES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        busy_i,
    input  logic        miso_i,
    output logic        cnv_o,
    output logic        cs_n_o,
    output logic        sclk_o,
    output logic [15:0] result_o,
    output logic        valid_o
);
    import conv_seq_pkg::*;

    logic              busy_fall;
    logic              byte_start;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;

    conv_seq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (busy_i),
        .fall_o  (busy_fall)
    );

    conv_seq_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start_i (byte_start),
        .miso_i  (miso_i),
        .sclk_o  (sclk_o),
        .done_o  (byte_done),
        .byte_o  (rx_byte)
    );

    conv_seq_ctrl #(.CNV_CYCLES(CNV_CYCLES)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .busy_fall_i  (busy_fall),
        .byte_done_i  (byte_done),
        .byte_i       (rx_byte),
        .cnv_o        (cnv_o),
        .cs_n_o       (cs_n_o),
        .byte_start_o (byte_start),
        .result_o     (result_o),
        .valid_o      (valid_o)
    );

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick_i,
    input logic        cnv_o,
    input logic        cs_n_o,
    input logic        sclk_o,
    input logic [15:0] result_o,
    input logic        valid_o
);

    AST_CNV_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_o) |-> $past(tick_i)); // R2

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o); // R5

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R9

    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o)); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o)); // R9

    AST_NO_CNV_DURING_CS: assert property (@(posedge clk) disable iff (rst)
        !(cnv_o && !cs_n_o)); // R11

    AST_NO_CNV_AFTER_CNV_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && $past(!cs_n_o)) |-> !$rose(cnv_o)); // R10

endmodule

bind conv_seq_top conv_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .cnv_o    (cnv_o),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .result_o (result_o),
    .valid_o  (valid_o)
);

// File: tb/tb_conv_seq_top.sv
`timescale 1ns/1ps
module tb_conv_seq_top;

    localparam int    CLK_DIV    = 4;
    localparam int    CNV_CYCLES = 3;
    localparam real   TCLK       = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        busy_i = 1'b0;
    logic        miso_i = 1'b0;
    logic        cnv_o, cs_n_o, sclk_o, valid_o;
    logic [15:0] result_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_q[$];
    logic [15:0] slave_word = '0;
    int          bit_idx = 0;
    int          rises = 0;
    real         t_r0 = 0.0, t_r1 = 0.0;
    int          cnv_pulses = 0;
    int          cs_rises = 0;
    logic        prev_cnv = 1'b0, prev_cs = 1'b1, prev_valid = 1'b0;

    always #4 clk = ~clk;

    conv_seq_top #(.CLK_DIV(CLK_DIV), .CNV_CYCLES(CNV_CYCLES), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .busy_i(busy_i), .miso_i(miso_i),
        .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .result_o(result_o), .valid_o(valid_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // converter model: launches the next bit on each rising serial clock edge
    always @(posedge sclk_o) begin
        if (!cs_n_o) begin
            if (rises == 0) t_r0 = $realtime;
            if (rises == 1) t_r1 = $realtime;
            if (bit_idx < 16) miso_i = slave_word[15 - bit_idx];
            bit_idx++;
            rises++;
        end
    end

    // edge counters and scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cnv_o && !prev_cnv) cnv_pulses++;
            if (cs_n_o && !prev_cs) cs_rises++;
            if (prev_valid) chk(!valid_o, "R9 valid width", valid_o, 0);
            if (valid_o) begin
                chk(cs_n_o, "R9 cs high with valid", cs_n_o, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", result_o, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(result_o == e, "R8 result word", result_o, e);
                end
            end
        end
        prev_cnv   = cnv_o;
        prev_cs    = cs_n_o;
        prev_valid = valid_o;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_conv(input logic [15:0] w, input bit hold_low_first);
        int n;
        int p0, c0;
        bit cs_seen;
        slave_word = w;
        bit_idx    = 0;
        rises      = 0;
        exp_q.push_back(w);
        p0 = cnv_pulses;
        c0 = cs_rises;
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        n = 0;
        while (cnv_o && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == CNV_CYCLES, "R2 start pulse length", n, CNV_CYCLES);
        if (hold_low_first) begin
            cs_seen = 1'b0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (!cs_n_o) cs_seen = 1'b1;
            end
            chk(!cs_seen, "R3 low level does not start readout", cs_seen, 0);
        end
        busy_i = 1'b1;
        cycles(2);
        tick_i = 1'b1;               // R10: tick while converting
        @(negedge clk) tick_i = 1'b0;
        cycles(3);
        chk(cs_n_o, "R3 no readout while busy high", cs_n_o, 1);
        busy_i = 1'b0;
        n = 0;
        while (cs_n_o && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(!cs_n_o, "R3 readout after busy fall", cs_n_o, 0);
        cycles(10);
        tick_i = 1'b1;               // R10: tick during transfer
        @(negedge clk) tick_i = 1'b0;
        n = 0;
        while (!cs_n_o && n < 500) begin
            n++;
            @(negedge clk);
        end
        chk(rises == 16, "R5 serial clock edges", rises, 16);
        chk(sclk_o == 1'b0, "R5 clock idles low", sclk_o, 0);
        chk((t_r1 - t_r0) == CLK_DIV * TCLK, "R6 serial clock period",
            longint'(t_r1 - t_r0), longint'(CLK_DIV * TCLK));
        cycles(10);
        chk(cs_rises - c0 == 1, "R7 one chip-select window", cs_rises - c0, 1);
        chk(cnv_pulses - p0 == 1, "R10 ticks ignored when busy", cnv_pulses - p0, 1);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cycles(5);
        chk(cs_n_o && !sclk_o && !cnv_o && !valid_o && result_o == 0,
            "R1 state in reset", {cs_n_o, sclk_o, cnv_o, valid_o}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n_o && !sclk_o && !cnv_o && !valid_o && result_o == 0,
            "R1 state after reset", {cs_n_o, sclk_o, cnv_o, valid_o}, 4'b1000);

        // R4: busy edge with nothing requested
        begin
            bit cs_seen;
            cs_seen = 1'b0;
            busy_i = 1'b1;
            cycles(4);
            busy_i = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!cs_n_o) cs_seen = 1'b1;
            end
            chk(!cs_seen, "R4 stray busy edge ignored", cs_seen, 0);
        end

        run_conv(16'hA55A, 1'b0);
        run_conv(16'h00FF, 1'b0);
        run_conv(16'hFF00, 1'b1);
        run_conv(16'h8001, 1'b0);
        run_conv(16'h3C96, 1'b1);

        cycles(40);
        chk(result_o == 16'h3C96, "R9 result held while idle", result_o, 16'h3C96);
        chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
        chk(cs_n_o && !cnv_o, "R11 idle outputs", {cs_n_o, cnv_o}, 2'b10);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule